// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This unit sits in the decode stage of an in-order pipeline whose functional units take different numbers of cycles to produce a result. Each cycle it looks at the decoded instruction (unit class, two source register indices, a destination index and a write flag) and decides whether the instruction may leave decode now or must wait. While it waits, fetch and decode are frozen and a bubble goes downstream.

Two things hold an instruction back. The first is an operand whose producer is still computing. Every register has a countdown that is loaded when a writer issues and falls by one each cycle. The second is a unit that has not yet reached its initiation interval since its last issue. When the instruction does issue, each source also gets a hint. The hint says whether the operand must be taken from a bypass path and which unit class produced it, or whether the register file already holds it.

Top module: `ilk_issue_ctl`

## Requirements
- R1: After reset every countdown and every unit gap is clear: the first instruction issues without stalling and both hints read 3'b000 (register file).
- R2: `stall` is high only when `dec_valid` is high and the instruction cannot issue. `issue` equals `dec_valid` and not `stall`, so the two are never high together.
- R3: Unit class encoding is 0 integer, 1 load, 2 FP add, 3 multiply. A consumer presented in the cycle right after a load that writes its source stalls LAT_LOAD cycles (default 1).
- R4: A consumer presented right after an FP add that writes its source stalls LAT_FADD cycles (default 3).
- R5: A consumer presented right after a multiply that writes its source stalls LAT_MUL cycles (default 6).
- R6: A consumer presented right after an integer writer of its source issues with no stall and takes the value from the bypass.
- R7: A forward hint is 3 bits: bit 2 set means bypass, bits 1:0 give the producer's unit class. Once a source is ready, the hint reads {1,class} for FWD_WIN cycles (default 2) and then 3'b000.
- R8: An operation issues to a unit only when at least II cycles have passed since that unit's last issue. Back-to-back independent operations on a unit with II=3 therefore stall 2 cycles, while a different unit is not held.
- R9: An instruction with `dec_wr` low leaves the destination's countdown unchanged, so a later reader of that register neither stalls nor reports a bypass.
- R10: While `dec_valid` is low, neither `issue` nor `stall` is raised, and the pending countdowns keep falling. A multiply consumer presented after 4 idle cycles stalls LAT_MUL-4 cycles.
- R11: A chain of a load, a dependent multiply, a dependent FP add and a dependent store takes 4 + LAT_LOAD + LAT_MUL + LAT_FADD cycles from the first presentation to the issue of the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is present |
| dec_class | input | 2 | Unit class: 0 integer, 1 load, 2 FP add, 3 multiply |
| dec_src_a | input | $clog2(NREG) | First source register index |
| dec_src_b | input | $clog2(NREG) | Second source register index |
| dec_dst | input | $clog2(NREG) | Destination register index |
| dec_wr | input | 1 | Instruction writes dec_dst |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Hold fetch and decode, send a bubble |
| fwd_a | output | 3 | Forward hint for source A: {bypass, class} |
| fwd_b | output | 3 | Forward hint for source B: {bypass, class} |

## Verification
The case that is hardest to reach from the ports is a unit gap and a register countdown that both expire while other state is still moving. The initiation-interval gate never blocks at the default interval of 1. For that reason the bench builds the block with a multiply interval of 3 and sends two independent multiplies back to back. It then inserts idle cycles between a multiply and its consumer, which shows that the countdowns keep falling while decode is empty. The forward window edge is reached by placing the consumer exactly one and exactly two cycles after an integer producer.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  typedef enum logic [1:0] {
    UC_INT  = 2'd0,
    UC_LOAD = 2'd1,
    UC_FADD = 2'd2,
    UC_MUL  = 2'd3
  } unit_class_e;

  localparam int NUM_UNITS = 4;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // operand usable by the consumer once its countdown is inside the forward window
  function automatic logic opnd_ready(input int cnt, input int win);
    return cnt <= win;
  endfunction

  // value lives only on a bypass path: ready but not yet in the register file
  function automatic logic on_bypass(input int cnt, input int win);
    return (cnt != 0) && (cnt <= win);
  endfunction

  // gap counter value loaded when a unit accepts an operation
  function automatic int gap_reload(input int ii);
    return (ii > 1) ? ii - 1 : 0;
  endfunction
endpackage

// File: rtl/ilk_reg_track.sv
module ilk_reg_track
  import ilk_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int CW       = 4,
  parameter int FWD_WIN  = 2,
  parameter int LAT_INT  = 0,
  parameter int LAT_LOAD = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [$clog2(NREG)-1:0]          wr_idx,
  input  unit_class_e                      wr_class,
  input  logic [1:0][$clog2(NREG)-1:0]     rd_idx,
  output logic [1:0]                       rdy,
  output logic [1:0][2:0]                  hint
);
  localparam int IW = $clog2(NREG);

  logic [CW-1:0] cnt [NREG];
  unit_class_e   own [NREG];

  function automatic logic [CW-1:0] load_val(input unit_class_e c);
    case (c)
      UC_LOAD: return CW'(LAT_LOAD + FWD_WIN);
      UC_FADD: return CW'(LAT_FADD + FWD_WIN);
      UC_MUL:  return CW'(LAT_MUL + FWD_WIN);
      default: return CW'(LAT_INT + FWD_WIN);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n) begin
        cnt[r] <= '0;
        own[r] <= UC_INT;
      end else if (wr_en && wr_idx == IW'(r)) begin
        cnt[r] <= load_val(wr_class);
        own[r] <= wr_class;
      end else if (cnt[r] != '0) begin
        cnt[r] <= cnt[r] - 1'b1;
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    logic [CW-1:0] c_sel;
    logic          byp;
    assign c_sel   = cnt[rd_idx[p]];
    assign rdy[p]  = opnd_ready(int'(c_sel), FWD_WIN);
    assign byp     = on_bypass(int'(c_sel), FWD_WIN);
    assign hint[p] = byp ? {1'b1, own[rd_idx[p]]} : 3'b000;
  end
endmodule

// File: rtl/ilk_unit_gate.sv
module ilk_unit_gate
  import ilk_pkg::*;
#(
  parameter int IIW     = 2,
  parameter int II_INT  = 1,
  parameter int II_LOAD = 1,
  parameter int II_FADD = 1,
  parameter int II_MUL  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  unit_class_e cls,
  output logic        busy
);
  logic [IIW-1:0]       gap [NUM_UNITS];
  logic [NUM_UNITS-1:0] busy_vec;

  function automatic logic [IIW-1:0] reload_of(input int u);
    case (u)
      1:       return IIW'(gap_reload(II_LOAD));
      2:       return IIW'(gap_reload(II_FADD));
      3:       return IIW'(gap_reload(II_MUL));
      default: return IIW'(gap_reload(II_INT));
    endcase
  endfunction

  always_ff @(posedge clk) begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (!rst_n)
        gap[u] <= '0;
      else if (take && cls == unit_class_e'(u))
        gap[u] <= reload_of(u);
      else if (gap[u] != '0)
        gap[u] <= gap[u] - 1'b1;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_busy
    assign busy_vec[u] = (gap[u] != '0);
  end

  assign busy = busy_vec[cls];
endmodule

// File: rtl/ilk_issue_ctl.sv
module ilk_issue_ctl
  import ilk_pkg::*;
#(
  parameter int NREG     = 8,
  parameter int FWD_WIN  = 2,
  parameter int LAT_INT  = 0,
  parameter int LAT_LOAD = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 6,
  parameter int II_INT   = 1,
  parameter int II_LOAD  = 1,
  parameter int II_FADD  = 1,
  parameter int II_MUL   = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dec_valid,
  input  logic [1:0]              dec_class,
  input  logic [$clog2(NREG)-1:0] dec_src_a,
  input  logic [$clog2(NREG)-1:0] dec_src_b,
  input  logic [$clog2(NREG)-1:0] dec_dst,
  input  logic                    dec_wr,
  output logic                    issue,
  output logic                    stall,
  output logic [2:0]              fwd_a,
  output logic [2:0]              fwd_b
);
  localparam int MAXL  = max4(LAT_INT, LAT_LOAD, LAT_FADD, LAT_MUL) + FWD_WIN;
  localparam int CW    = $clog2(MAXL + 1);
  localparam int MAXII = max4(II_INT, II_LOAD, II_FADD, II_MUL);
  localparam int IIW   = (MAXII > 1) ? $clog2(MAXII) : 1;

  unit_class_e                 cls;
  logic [1:0][$clog2(NREG)-1:0] rd_idx;
  logic [1:0]                  src_rdy;
  logic [1:0][2:0]             src_hint;
  logic                        opnd_hazard;
  logic                        unit_busy;
  logic                        dst_write;

  assign cls    = unit_class_e'(dec_class);
  assign rd_idx = {dec_src_b, dec_src_a};

  ilk_reg_track #(
    .NREG(NREG), .CW(CW), .FWD_WIN(FWD_WIN),
    .LAT_INT(LAT_INT), .LAT_LOAD(LAT_LOAD), .LAT_FADD(LAT_FADD), .LAT_MUL(LAT_MUL)
  ) u_track (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dst_write), .wr_idx(dec_dst), .wr_class(cls),
    .rd_idx(rd_idx), .rdy(src_rdy), .hint(src_hint)
  );

  ilk_unit_gate #(
    .IIW(IIW), .II_INT(II_INT), .II_LOAD(II_LOAD), .II_FADD(II_FADD), .II_MUL(II_MUL)
  ) u_gate (
    .clk(clk), .rst_n(rst_n), .take(issue), .cls(cls), .busy(unit_busy)
  );

  assign opnd_hazard = !(&src_rdy);
  assign stall       = dec_valid && (opnd_hazard || unit_busy);
  assign issue       = dec_valid && !stall;
  assign dst_write   = issue && dec_wr;
  assign fwd_a       = src_hint[0];
  assign fwd_b       = src_hint[1];
endmodule

// File: rtl/ilk_issue_chk.sv
module ilk_issue_chk #(
  parameter int NREG     = 8,
  parameter int LAT_LOAD = 1,
  parameter int LAT_MUL  = 6,
  parameter int II_INT   = 1,
  parameter int II_LOAD  = 1,
  parameter int II_FADD  = 1,
  parameter int II_MUL   = 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dec_valid,
  input logic [1:0]              dec_class,
  input logic [$clog2(NREG)-1:0] dec_src_a,
  input logic [$clog2(NREG)-1:0] dec_src_b,
  input logic [$clog2(NREG)-1:0] dec_dst,
  input logic                    dec_wr,
  input logic                    issue,
  input logic                    stall,
  input logic                    unit_busy
);
  logic       armed;
  logic [7:0] since [4];

  function automatic int ii_of(input int u);
    case (u)
      1:       return II_LOAD;
      2:       return II_FADD;
      3:       return II_MUL;
      default: return II_INT;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
    for (int u = 0; u < 4; u++) begin
      if (!rst_n)                             since[u] <= 8'd255;
      else if (issue && dec_class == 2'(u))   since[u] <= 8'd1;
      else if (since[u] != 8'd255)            since[u] <= since[u] + 8'd1;
    end
  end

  a_r2_issue_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));

  a_r2_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> dec_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!issue && !stall && !unit_busy) || unit_busy);

  for (genvar u = 0; u < 4; u++) begin : g_ii
    a_r8_ii_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && dec_class == 2'(u)) |-> (int'(since[u]) >= ii_of(u)));
  end

  if (LAT_LOAD > 0) begin : g_ld
    a_r3_load_use_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && dec_valid && $past(issue && dec_wr && dec_class == 2'd1) &&
       (dec_src_a == $past(dec_dst) || dec_src_b == $past(dec_dst))) |-> stall);
  end

  if (LAT_MUL > 0) begin : g_mul
    a_r5_mul_use_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && dec_valid && $past(issue && dec_wr && dec_class == 2'd3) &&
       (dec_src_a == $past(dec_dst) || dec_src_b == $past(dec_dst))) |-> stall);
  end
endmodule

bind ilk_issue_ctl ilk_issue_chk #(
  .NREG(NREG), .LAT_LOAD(LAT_LOAD), .LAT_MUL(LAT_MUL),
  .II_INT(II_INT), .II_LOAD(II_LOAD), .II_FADD(II_FADD), .II_MUL(II_MUL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
  .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst), .dec_wr(dec_wr),
  .issue(issue), .stall(stall), .unit_busy(unit_busy)
);

// File: tb/sim_ilk_issue_ctl.sv
`timescale 1ns/1ps
module sim_ilk_issue_ctl;
  localparam int M_LAT_LOAD = 1;
  localparam int M_LAT_FADD = 3;
  localparam int M_LAT_MUL  = 6;
  localparam int M_II_MUL   = 3;
  localparam int M_WIN      = 2;

  localparam logic [1:0] C_INT = 2'd0, C_LD = 2'd1, C_FA = 2'd2, C_MU = 2'd3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic [1:0] dec_class = 2'd0;
  logic [2:0] dec_src_a = 3'd0, dec_src_b = 3'd0, dec_dst = 3'd0;
  logic       dec_wr = 1'b0;
  logic       issue, stall;
  logic [2:0] fwd_a, fwd_b;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ilk_issue_ctl #(.II_MUL(M_II_MUL)) u0 (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst), .dec_wr(dec_wr),
    .issue(issue), .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // present one instruction at a falling edge; return stall cycles and hints
  task automatic present(input logic [1:0] c, input logic [2:0] a, input logic [2:0] b,
                         input logic [2:0] d, input logic w,
                         output int stalls, output logic [2:0] ha, output logic [2:0] hb);
    dec_class = c; dec_src_a = a; dec_src_b = b; dec_dst = d; dec_wr = w;
    dec_valid = 1'b1;
    #1;
    stalls = 0;
    while (!issue && stalls < 60) begin
      stalls++;
      @(negedge clk); #1;
    end
    ha = fwd_a; hb = fwd_b;
    chk(int'(stall), 0, "R2 stall low while issuing");
    @(negedge clk);
    dec_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    dec_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      #1;
      chk(int'(issue || stall), 0, "R10 quiet while idle");
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int s; logic [2:0] ha, hb;
    #1;
    chk(int'(issue), 0, "R1 no issue after reset");
    chk(int'(stall), 0, "R1 no stall after reset");
    present(C_INT, 3'd2, 3'd3, 3'd1, 1'b1, s, ha, hb);
    chk(s, 0, "R1 first issue stalls");
    chk(int'(ha), 0, "R1 hint a after reset");
    chk(int'(hb), 0, "R1 hint b after reset");
  endtask

  task automatic t_int_fwd();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_INT, 3'd2, 3'd3, 3'd1, 1'b1, s, ha, hb);
    present(C_INT, 3'd1, 3'd1, 3'd4, 1'b1, s, ha, hb);
    chk(s, 0, "R6 integer consumer stalls");
    chk(int'(ha), 3'b100, "R6 integer bypass hint");
  endtask

  task automatic t_load();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_LD, 3'd0, 3'd0, 3'd2, 1'b1, s, ha, hb);
    present(C_INT, 3'd2, 3'd5, 3'd3, 1'b1, s, ha, hb);
    chk(s, M_LAT_LOAD, "R3 load-use stall cycles");
    chk(int'(ha), 3'b101, "R7 load bypass hint");
    chk(int'(hb), 3'b000, "R7 untouched source hint");
  endtask

  task automatic t_fadd();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_FA, 3'd0, 3'd1, 3'd3, 1'b1, s, ha, hb);
    present(C_INT, 3'd5, 3'd3, 3'd4, 1'b1, s, ha, hb);
    chk(s, M_LAT_FADD, "R4 fadd consumer stall cycles");
    chk(int'(hb), 3'b110, "R7 fadd bypass hint");
  endtask

  task automatic t_mul();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_MU, 3'd0, 3'd1, 3'd6, 1'b1, s, ha, hb);
    present(C_INT, 3'd6, 3'd0, 3'd4, 1'b1, s, ha, hb);
    chk(s, M_LAT_MUL, "R5 mul consumer stall cycles");
    chk(int'(ha), 3'b111, "R7 mul bypass hint");
  endtask

  task automatic t_window();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_INT, 3'd0, 3'd0, 3'd5, 1'b1, s, ha, hb);
    idle(M_WIN - 1);
    present(C_INT, 3'd5, 3'd0, 3'd1, 1'b1, s, ha, hb);
    chk(int'(ha), 3'b100, "R7 last bypass cycle");
    idle(10);
    present(C_INT, 3'd0, 3'd0, 3'd6, 1'b1, s, ha, hb);
    idle(M_WIN);
    present(C_INT, 3'd6, 3'd0, 3'd1, 1'b1, s, ha, hb);
    chk(int'(ha), 3'b000, "R7 register file after window");
  endtask

  task automatic t_ii();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_MU, 3'd2, 3'd3, 3'd1, 1'b1, s, ha, hb);
    present(C_MU, 3'd5, 3'd6, 3'd4, 1'b1, s, ha, hb);
    chk(s, M_II_MUL - 1, "R8 multiply initiation gap");
    present(C_FA, 3'd5, 3'd6, 3'd7, 1'b1, s, ha, hb);
    chk(s, 0, "R8 other unit not held");
  endtask

  task automatic t_nowrite();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_FA, 3'd0, 3'd0, 3'd2, 1'b0, s, ha, hb);
    present(C_INT, 3'd2, 3'd2, 3'd3, 1'b1, s, ha, hb);
    chk(s, 0, "R9 non-writer leaves no hazard");
    chk(int'(ha), 3'b000, "R9 non-writer leaves no bypass");
  endtask

  task automatic t_decay();
    int s; logic [2:0] ha, hb;
    idle(10);
    present(C_MU, 3'd2, 3'd3, 3'd1, 1'b1, s, ha, hb);
    idle(4);
    present(C_INT, 3'd1, 3'd0, 3'd4, 1'b1, s, ha, hb);
    chk(s, M_LAT_MUL - 4, "R10 countdown falls while idle");
  endtask

  task automatic t_chain();
    int s, total; logic [2:0] ha, hb;
    idle(10);
    total = 0;
    present(C_LD, 3'd0, 3'd0, 3'd1, 1'b1, s, ha, hb); total += 1 + s;
    present(C_MU, 3'd1, 3'd1, 3'd2, 1'b1, s, ha, hb); total += 1 + s;
    chk(s, M_LAT_LOAD, "R11 mul waits on load");
    present(C_FA, 3'd2, 3'd2, 3'd3, 1'b1, s, ha, hb); total += 1 + s;
    chk(s, M_LAT_MUL, "R11 fadd waits on mul");
    present(C_INT, 3'd3, 3'd4, 3'd0, 1'b0, s, ha, hb); total += s;
    chk(s, M_LAT_FADD, "R11 store waits on fadd");
    chk(total + 1, 4 + M_LAT_LOAD + M_LAT_MUL + M_LAT_FADD, "R11 chain cycle count");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_int_fwd();
    t_load();
    t_fadd();
    t_mul();
    t_window();
    t_ii();
    t_nowrite();
    t_decay();
    t_chain();
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule